// File: doc/BRIEF.md
# FIFO Ready Indicator Generator

This block produces the two active-low ready strobes of one serial channel: one telling a DMA engine or a polling loop that the receive buffer holds enough data to be worth draining, and one telling it that the transmit buffer has enough room to accept a burst. It does not hold any data. The fill count of the 64-entry receive buffer, the free-slot count of the 64-entry transmit buffer, two programmable thresholds, a receive-idle timeout pulse and a receive error flag all come in as synchronous inputs.

Each strobe is a latched state with set and clear conditions. The receive strobe is set when the fill count reaches its threshold or when a timeout pulse arrives, and is cleared by an empty buffer or a pending error. The clear wins when both happen at once. The transmit strobe is set when the free space reaches its threshold and is cleared only by a full buffer, which gives it hysteresis. Both strobes are registered. The reset is asserted asynchronously and released through a synchronizer.

Top module: `fifo_ready_gen`

## Requirements
- R1: While rst_n is low, and at the first two rising clock edges after rst_n goes high, rx_ready_n and tx_ready_n are both 1. The inputs have no effect during that time.
- R2: When rx_count is nonzero, rx_error is 0 and rx_count is at least the effective receive threshold, rx_ready_n is 0 after the next rising edge.
- R3: When rx_timeout is 1 at a rising edge, with rx_count nonzero and rx_error 0, rx_ready_n becomes 0 even if rx_count is below the threshold.
- R4: When rx_count is 0 or rx_error is 1 at a rising edge, rx_ready_n becomes 1. This clear overrides any set condition present in the same cycle.
- R5: Once low, rx_ready_n stays low while there is no clear condition, even if rx_count falls below the threshold. Once high, it stays high while there is no set condition.
- R6: When tx_free is nonzero and at least the effective transmit threshold, tx_ready_n is 0 after the next rising edge.
- R7: When tx_free is 0 at a rising edge, tx_ready_n becomes 1. It then stays 1 until tx_free again reaches the threshold. While tx_ready_n is low, it stays low when tx_free falls below the threshold but stays nonzero.
- R8: A threshold input of 0 acts as 1. A threshold input above 64 acts as 64. Values from 1 to 64 are used unchanged.
- R9: Both outputs are register outputs. Each reflects the inputs sampled at the preceding rising edge and never changes between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 7 | Entries currently held in the receive buffer (0 to 64) |
| rx_trig | input | 7 | Receive threshold |
| rx_timeout | input | 1 | Single-cycle receive idle timeout pulse |
| rx_error | input | 1 | Receive buffer holds an errored entry |
| tx_free | input | 7 | Free slots in the transmit buffer (0 to 64) |
| tx_trig | input | 7 | Transmit free-space threshold |
| rx_ready_n | output | 1 | Receive ready, active low |
| tx_ready_n | output | 1 | Transmit ready, active low |

## Verification
Each strobe is a single bit of state, so a wrong internal value shows up at its output pin one edge after the inputs that caused it. A lost timeout latch, a clear that loses to a set, or a transmit strobe that re-arms below its threshold shows as a mismatch against the reference model in the very next cycle. Hysteresis faults only show when the count moves through the band between zero and the threshold. The directed sequences therefore walk the counts up and down across that band, and a long randomized run follows to mix the timeout, error and threshold saturation cases.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;
  localparam int unsigned DEF_DEPTH  = 64;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum logic {
    RDY_OFF = 1'b0,
    RDY_ON  = 1'b1
  } rdy_state_e;
endpackage

// File: rtl/rdy_rst_sync.sv
module rdy_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rdy_trig_sat.sv
module rdy_trig_sat #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input  logic [CW-1:0] trig_raw,
  output logic [CW-1:0] trig_eff
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    if (trig_raw == '0)      trig_eff = ONE;
    else if (trig_raw > TOP) trig_eff = TOP;
    else                     trig_eff = trig_raw;
  end
endmodule

// File: rtl/rdy_flag_reg.sv
module rdy_flag_reg
  import fifo_rdy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  rdy_state_e state_q;
  rdy_state_e state_d;
  logic       upd_en;

  // clear wins over set
  always_comb begin
    upd_en  = set_i | clr_i;
    state_d = state_q;
    if (clr_i)      state_d = RDY_OFF;
    else if (set_i) state_d = RDY_ON;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= RDY_OFF;
    else if (upd_en) state_q <= state_d;
  end

  assign flag_o = (state_q == RDY_ON);

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_o);
  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_o);
  a_r5_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/fifo_ready_gen.sv
module fifo_ready_gen
  import fifo_rdy_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned STAGES = DEF_STAGES,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic          rx_error,
  input  logic [CW-1:0] tx_free,
  input  logic [CW-1:0] tx_trig,
  output logic          rx_ready_n,
  output logic          tx_ready_n
);
  localparam int unsigned NCH = 2;  // 0: receive, 1: transmit

  logic          rst_int_n;
  logic [CW-1:0] trig_raw [NCH];
  logic [CW-1:0] trig_eff [NCH];
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] clr_v;
  logic [NCH-1:0] flag_v;

  rdy_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  assign trig_raw[0] = rx_trig;
  assign trig_raw[1] = tx_trig;

  always_comb begin
    set_v[0] = (rx_count >= trig_eff[0]) | rx_timeout;
    clr_v[0] = (rx_count == '0) | rx_error;
    set_v[1] = (tx_free >= trig_eff[1]);
    clr_v[1] = (tx_free == '0);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rdy_trig_sat #(.DEPTH(DEPTH), .CW(CW)) u_sat (
      .trig_raw(trig_raw[g]), .trig_eff(trig_eff[g])
    );
    rdy_flag_reg u_flag (
      .clk(clk), .rst_n(rst_int_n),
      .set_i(set_v[g]), .clr_i(clr_v[g]), .flag_o(flag_v[g])
    );
  end

  assign rx_ready_n = ~flag_v[0];
  assign tx_ready_n = ~flag_v[1];

  a_r1_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (rx_ready_n && tx_ready_n));
  a_r8_trig_bounds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (trig_eff[0] != '0) && (trig_eff[0] <= CW'(DEPTH)) &&
    (trig_eff[1] != '0) && (trig_eff[1] <= CW'(DEPTH)));
  a_r3_timeout_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_timeout && !rx_error && rx_count != '0) |=> !rx_ready_n);
  a_r7_full_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_free == '0) |=> tx_ready_n);
endmodule

// File: tb/tb_fifo_ready_gen.sv
`timescale 1ns/1ps
module tb_fifo_ready_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] rx_count, rx_trig, tx_free, tx_trig;
  logic       rx_timeout, rx_error;
  logic       rx_ready_n, tx_ready_n;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  bit    model_en = 1'b0;
  bit    rx_m = 1'b0;
  bit    tx_m = 1'b0;
  string req  = "R1";

  always #2.5 clk = ~clk;

  fifo_ready_gen dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_trig(rx_trig),
    .rx_timeout(rx_timeout), .rx_error(rx_error), .tx_free(tx_free),
    .tx_trig(tx_trig), .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n)
  );

  function automatic int eff(input logic [6:0] t);
    if (t == 0) return 1;
    if (t > 64) return 64;
    return int'(t);
  endfunction

  // behavioural reference, updated at each rising edge (R2..R9)
  always @(posedge clk) begin
    if (model_en) begin
      if (rx_count == 0 || rx_error)                        rx_m = 1'b0;
      else if (int'(rx_count) >= eff(rx_trig) || rx_timeout) rx_m = 1'b1;
      if (tx_free == 0)                                     tx_m = 1'b0;
      else if (int'(tx_free) >= eff(tx_trig))               tx_m = 1'b1;
    end
  end

  task automatic check(input bit exp_rx, input bit exp_tx);
    n_run++;
    if (rx_ready_n !== exp_rx || tx_ready_n !== exp_tx) begin
      n_fail++;
      $display("FAIL %s: rx_ready_n=%b tx_ready_n=%b expected %b %b",
               req, rx_ready_n, tx_ready_n, exp_rx, exp_tx);
    end
  endtask

  // compare at the falling edge, then drive the next inputs
  task automatic cyc(input int rc, input int rt, input bit to, input bit er,
                     input int tf, input int tt);
    @(negedge clk);
    check(!rx_m, !tx_m);
    rx_count = 7'(rc); rx_trig = 7'(rt); rx_timeout = to; rx_error = er;
    tx_free = 7'(tf); tx_trig = 7'(tt);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_count = 7'd64; rx_trig = 7'd1; rx_timeout = 1'b1; rx_error = 1'b0;
    tx_free = 7'd64; tx_trig = 7'd1;
    // R1: held high in reset and at the first two edges after release
    req = "R1";
    repeat (4) begin @(negedge clk); check(1'b1, 1'b1); end
    rst_n = 1'b1;
    repeat (2) begin @(negedge clk); check(1'b1, 1'b1); end
    rx_count = 0; rx_timeout = 0; tx_free = 0;
    model_en = 1'b1;
    cyc(0, 8, 0, 0, 0, 16);

    // R2: threshold reached while counting up
    req = "R2";
    for (int i = 1; i <= 9; i++) cyc(i, 8, 0, 0, 10, 16);
    // R5: stays low while draining below threshold
    req = "R5";
    for (int i = 7; i >= 1; i--) cyc(i, 8, 0, 0, 10, 16);
    // R4: empty clears, then error clears with set present
    req = "R4";
    cyc(0, 8, 0, 0, 10, 16);
    cyc(20, 8, 0, 0, 10, 16);
    cyc(20, 8, 1, 1, 10, 16);
    cyc(20, 8, 0, 0, 10, 16);
    cyc(0, 8, 1, 0, 10, 16);
    cyc(0, 8, 0, 0, 10, 16);
    // R3: timeout below threshold latches
    req = "R3";
    cyc(3, 32, 0, 0, 10, 16);
    cyc(3, 32, 1, 0, 10, 16);
    cyc(2, 32, 0, 0, 10, 16);
    cyc(1, 32, 0, 0, 10, 16);
    cyc(0, 32, 0, 0, 10, 16);
    cyc(5, 32, 0, 0, 10, 16);
    // R6 / R7: transmit hysteresis
    req = "R6";
    cyc(0, 8, 0, 0, 15, 16);
    cyc(0, 8, 0, 0, 16, 16);
    cyc(0, 8, 0, 0, 40, 16);
    req = "R7";
    cyc(0, 8, 0, 0, 5, 16);
    cyc(0, 8, 0, 0, 1, 16);
    cyc(0, 8, 0, 0, 0, 16);
    cyc(0, 8, 0, 0, 10, 16);
    cyc(0, 8, 0, 0, 15, 16);
    cyc(0, 8, 0, 0, 16, 16);
    cyc(0, 8, 0, 0, 16, 16);
    // R8: threshold saturation
    req = "R8";
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1, 0);
    cyc(0, 100, 0, 0, 0, 127);
    cyc(63, 100, 0, 0, 63, 127);
    cyc(64, 100, 0, 0, 64, 127);
    cyc(64, 100, 0, 0, 64, 127);
    // R9: randomized mix, compared every cycle
    req = "R9";
    for (int i = 0; i < 3000; i++) begin
      int rc = (($urandom % 8) == 0) ? 0 : int'($urandom_range(64, 1));
      int tf = (($urandom % 8) == 0) ? 0 : int'($urandom_range(64, 1));
      cyc(rc, int'($urandom_range(127, 0)), ($urandom % 6) == 0,
          ($urandom % 10) == 0, tf, int'($urandom_range(127, 0)));
    end
    cyc(0, 8, 0, 0, 0, 8);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule